// File: doc/BRIEF.md
# Chopped Conversion Scheduler with Ready Handshake

This block paces the output of a chopped sigma-delta converter. A modulator-rate enable pulse advances a period counter whose length is 24 times a programmable decimation word. At the end of each period the block captures a 16-bit raw differential sample, recodes it into offset binary or straight binary, and stores it in the result register. It then signals the new result on an active-low ready line and on an active-high status bit.

The input is chopped, so the first result after reset, after a configuration change or on leaving standby takes two full periods. After that, one result arrives per period. Ready is forced inactive one modulator tick before every load, so a reader never samples a register that is being rewritten. A read-complete pulse from the serial port also releases ready. The stored result stays readable until the next load. The decimation word can only be changed while the block is in standby. Conversion runs from reset with the default word of 69 and needs no setup.

Top module: `chop_sched`

## Requirements
- R1: After reset, rdy_n is 1, status_rdy is 0 and data_out is 0000h. With no write, the decimation word is 69, so the first ready falls on modulator tick 3312 (2 × 24 × 69).
- R2: Once running, a new result is loaded every 24 × SF modulator ticks. data_out changes only on a cycle in which mod_tick is high.
- R3: After reset, a cfg_change pulse or a standby exit, the first result is loaded after exactly two periods (48 × SF ticks). cfg_change drives rdy_n high on the next cycle.
- R4: On the tick that loads a result, rdy_n goes to 0. It stays 0 until a read or a blanking tick. status_rdy always equals the inverse of rdy_n.
- R5: A rd_done pulse sets rdy_n to 1 on the next cycle and leaves data_out unchanged, so the same result can be read again.
- R6: rdy_n is driven to 1 on tick P−1 of each loading period of P ticks, even if the result was never read.
- R7: With unipolar = 0, the raw two's-complement sample is stored in offset binary (raw XOR 8000h). 8000h maps to 0000h, 0000h to 8000h and 7FFFh to FFFFh.
- R8: With unipolar = 1, a negative raw sample (bit 15 set) is stored as 0000h. A non-negative sample is stored as its bits 14..0 shifted up one place, with bit 14 copied into bit 0, so 0000h maps to 0000h and 7FFFh to FFFFh.
- R9: sf_wr loads sf_wdata into the decimation word only while standby is 1. At any other time it has no effect on the period.
- R10: A decimation word below 13 is used as 13.
- R11: While standby is 1, the period counter holds, rdy_n stays 1 and data_out does not change.
- R12: When rd_done and a loading tick occur in the same cycle, the load wins and rdy_n goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mod_tick | input | 1 | One-cycle modulator clock enable |
| standby | input | 1 | Stops conversion and holds ready inactive |
| cfg_change | input | 1 | Pulse: channel or configuration changed, restart the chop sequence |
| sf_wr | input | 1 | Write strobe for the decimation word |
| sf_wdata | input | 8 | New decimation word |
| unipolar | input | 1 | 1 selects straight binary, 0 selects offset binary |
| raw_sample | input | 16 | Raw two's-complement differential sample |
| rd_done | input | 1 | Pulse: a read of the result register has completed |
| data_out | output | 16 | Result register |
| rdy_n | output | 1 | Active-low data-ready |
| status_rdy | output | 1 | Active-high ready status bit |

## Verification
The period counter is exercised with decimation words 69 (the default), 13, 5 (clamped) and 255. Counting ticks to each ready edge shows whether the chopped first period is present and whether the multiply uses the right word and the right counter width. A write made while the block is active, compared against one made in standby, shows whether the write gate works. The coding paths use the two full-scale values, zero, a mid-scale value and a value with bit 14 set in each mode, which catches a missing sign flip, clamp or bit shift. The ready line is checked when the result is unread at the blanking tick, when it is read twice, and when a read coincides with a load, which tells the priority orders apart.

// File: rtl/sched_pkg.sv
package sched_pkg;

  // Output coding selected for the result register
  typedef enum logic {
    CODE_OFFSET   = 1'b0,
    CODE_STRAIGHT = 1'b1
  } code_mode_e;

  localparam int DEF_SF_W         = 8;
  localparam int DEF_DATA_W       = 16;
  localparam int DEF_TICKS_PER_SF = 24;
  localparam int DEF_SF_MIN       = 13;
  localparam int DEF_SF_RESET     = 69;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/period_timer.sv
module period_timer #(
  parameter int SF_W         = 8,
  parameter int TICKS_PER_SF = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            hold,
  input  logic            restart,
  input  logic [SF_W-1:0] sf_eff,
  output logic            load,
  output logic            blank
);

  localparam int MAX_TICKS = TICKS_PER_SF * ((1 << SF_W) - 1);
  localparam int CNT_W     = $clog2(MAX_TICKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             warm_q, warm_d;
  logic [CNT_W-1:0] last;
  logic             run;
  logic             at_last;

  always_comb begin
    last    = CNT_W'(TICKS_PER_SF) * CNT_W'(sf_eff) - CNT_W'(1);
    run     = tick && !hold && !restart;
    at_last = (cnt_q == last);
  end

  // Next state: the first period after a start only primes the chop pair
  always_comb begin
    cnt_d  = cnt_q;
    warm_d = warm_q;
    if (hold || restart) begin
      cnt_d  = '0;
      warm_d = 1'b0;
    end else if (tick) begin
      if (at_last) begin
        cnt_d  = '0;
        warm_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      warm_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      warm_q <= warm_d;
    end
  end

  assign load  = run && warm_q && at_last;
  assign blank = run && warm_q && (cnt_q == last - CNT_W'(1));

endmodule

// File: rtl/result_stage.sv
module result_stage
  import sched_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  code_mode_e        mode,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] data_q
);

  logic [DATA_W-1:0] coded;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    if (mode == CODE_STRAIGHT) begin
      if (raw[DATA_W-1]) coded = '0;
      else               coded = {raw[DATA_W-2:0], raw[DATA_W-2]};
    end else begin
      coded = {~raw[DATA_W-1], raw[DATA_W-2:0]};
    end
  end

  always_comb begin
    data_d = load ? coded : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

endmodule

// File: rtl/ready_ctrl.sv
module ready_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic blank,
  input  logic rd_done,
  input  logic force_idle,
  output logic rdy_n,
  output logic status_rdy
);

  logic rdy_n_d;
  logic stat_d;

  // A new load outranks every release source
  always_comb begin
    if (load)                             rdy_n_d = 1'b0;
    else if (blank || rd_done || force_idle) rdy_n_d = 1'b1;
    else                                  rdy_n_d = rdy_n;
    stat_d = ~rdy_n_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_n      <= 1'b1;
      status_rdy <= 1'b0;
    end else begin
      rdy_n      <= rdy_n_d;
      status_rdy <= stat_d;
    end
  end

endmodule

// File: rtl/chop_sched.sv
module chop_sched
  import sched_pkg::*;
#(
  parameter int SF_W         = DEF_SF_W,
  parameter int DATA_W       = DEF_DATA_W,
  parameter int TICKS_PER_SF = DEF_TICKS_PER_SF,
  parameter int SF_MIN       = DEF_SF_MIN,
  parameter int SF_RESET     = DEF_SF_RESET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_tick,
  input  logic              standby,
  input  logic              cfg_change,
  input  logic              sf_wr,
  input  logic [SF_W-1:0]   sf_wdata,
  input  logic              unipolar,
  input  logic [DATA_W-1:0] raw_sample,
  input  logic              rd_done,
  output logic [DATA_W-1:0] data_out,
  output logic              rdy_n,
  output logic              status_rdy
);

  localparam logic [SF_W-1:0] SF_MIN_V   = SF_W'(SF_MIN);
  localparam logic [SF_W-1:0] SF_RESET_V = SF_W'(SF_RESET);

  logic            rst_n_i;
  logic [SF_W-1:0] sf_q, sf_d;
  logic [SF_W-1:0] sf_eff;
  logic            load, blank;
  code_mode_e      mode;

  rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // Decimation word: writable only in standby, clamped where it is used
  always_comb begin
    sf_d   = (sf_wr && standby) ? sf_wdata : sf_q;
    sf_eff = (sf_q < SF_MIN_V) ? SF_MIN_V : sf_q;
    mode   = unipolar ? CODE_STRAIGHT : CODE_OFFSET;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sf_q <= SF_RESET_V;
    else          sf_q <= sf_d;
  end

  period_timer #(
    .SF_W         (SF_W),
    .TICKS_PER_SF (TICKS_PER_SF)
  ) u_period_timer (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .tick    (mod_tick),
    .hold    (standby),
    .restart (cfg_change),
    .sf_eff  (sf_eff),
    .load    (load),
    .blank   (blank)
  );

  result_stage #(.DATA_W(DATA_W)) u_result_stage (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .load   (load),
    .mode   (mode),
    .raw    (raw_sample),
    .data_q (data_out)
  );

  ready_ctrl u_ready_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .load       (load),
    .blank      (blank),
    .rd_done    (rd_done),
    .force_idle (standby || cfg_change),
    .rdy_n      (rdy_n),
    .status_rdy (status_rdy)
  );

endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mod_tick,
  input logic              standby,
  input logic              cfg_change,
  input logic              rd_done,
  input logic [DATA_W-1:0] data_out,
  input logic              rdy_n,
  input logic              status_rdy
);

  assert_tick_only_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_tick |=> $stable(data_out));

  assert_restart_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> rdy_n);

  assert_fall_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> $past(mod_tick));

  assert_status_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status_rdy == !rdy_n);

  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !mod_tick) |=> rdy_n);

  assert_standby_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (rdy_n && $stable(data_out)));

endmodule

bind chop_sched sched_checker #(.DATA_W(DATA_W)) u_sched_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .mod_tick   (mod_tick),
  .standby    (standby),
  .cfg_change (cfg_change),
  .rd_done    (rd_done),
  .data_out   (data_out),
  .rdy_n      (rdy_n),
  .status_rdy (status_rdy)
);

// File: tb/chop_sched_bench.sv
`timescale 1ns/1ps
module chop_sched_bench;

  logic        clk = 1'b0;
  logic        rst_n, mod_tick, standby, cfg_change, sf_wr, unipolar, rd_done;
  logic [7:0]  sf_wdata;
  logic [15:0] raw_sample, data_out;
  logic        rdy_n, status_rdy;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chop_sched u_chop_sched (
    .clk(clk), .rst_n(rst_n), .mod_tick(mod_tick), .standby(standby),
    .cfg_change(cfg_change), .sf_wr(sf_wr), .sf_wdata(sf_wdata),
    .unipolar(unipolar), .raw_sample(raw_sample), .rd_done(rd_done),
    .data_out(data_out), .rdy_n(rdy_n), .status_rdy(status_rdy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic one_tick(input logic with_rd);
    @(negedge clk); mod_tick = 1'b1; rd_done = with_rd;
    @(negedge clk); mod_tick = 1'b0; rd_done = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_done = 1'b1;
    @(negedge clk); rd_done = 1'b0;
  endtask

  task automatic write_sf(input logic [7:0] v);
    @(negedge clk); standby = 1'b1;
    @(negedge clk); sf_wr = 1'b1; sf_wdata = v;
    @(negedge clk); sf_wr = 1'b0;
    @(negedge clk); standby = 1'b0;
  endtask

  // Ticks until a fresh ready; rose = tick at which ready was released first
  task automatic wait_ready(input int limit, output int n, output int rose);
    logic seen_high;
    seen_high = (rdy_n === 1'b1);
    n = -1; rose = -1;
    for (int i = 1; i <= limit; i++) begin
      one_tick(1'b0);
      if (!seen_high && rdy_n === 1'b1) begin seen_high = 1'b1; rose = i; end
      if (seen_high && rdy_n === 1'b0) begin n = i; break; end
    end
  endtask

  task automatic t_reset();
    chk("R1 rdy_n", rdy_n, 1);
    chk("R1 status", status_rdy, 0);
    chk("R1 data", data_out, 16'h0000);
  endtask

  task automatic t_default_start();
    int n, r;
    raw_sample = 16'h0000;
    wait_ready(4000, n, r);
    chk("R1 R3 first ready tick at default SF", n, 3312);
    chk("R7 zero to 8000h", data_out, 16'h8000);
    chk("R4 status set", status_rdy, 1);
  endtask

  task automatic t_write_ignored();
    int n, r;
    @(negedge clk); sf_wr = 1'b1; sf_wdata = 8'd13;
    @(negedge clk); sf_wr = 1'b0;
    raw_sample = 16'h8000;
    wait_ready(2000, n, r);
    chk("R6 blank before unread load", r, 1655);
    chk("R9 R2 period unchanged by active write", n, 1656);
    chk("R7 neg full scale", data_out, 16'h0000);
  endtask

  task automatic t_standby();
    int n, r;
    logic bad;
    @(negedge clk); standby = 1'b1;
    @(negedge clk);
    chk("R11 standby releases ready", rdy_n, 1);
    raw_sample = 16'h1111;
    bad = 1'b0;
    for (int i = 0; i < 300; i++) begin
      one_tick(1'b0);
      if (rdy_n !== 1'b1 || data_out !== 16'h0000) bad = 1'b1;
    end
    chk("R11 no activity in standby", bad, 0);
    @(negedge clk); sf_wr = 1'b1; sf_wdata = 8'd13;
    @(negedge clk); sf_wr = 1'b0; standby = 1'b0;
    raw_sample = 16'h7FFF;
    wait_ready(1000, n, r);
    chk("R3 R9 two periods after standby exit SF13", n, 624);
    chk("R7 pos full scale", data_out, 16'hFFFF);
    raw_sample = 16'h1234;
    wait_ready(1000, n, r);
    chk("R6 blank tick SF13", r, 311);
    chk("R2 period SF13", n, 312);
    chk("R7 mid value", data_out, 16'h9234);
  endtask

  task automatic t_collide();
    for (int i = 0; i < 310; i++) one_tick(1'b0);
    chk("R4 ready held while unread", rdy_n, 0);
    one_tick(1'b0);
    chk("R6 forced high unread", rdy_n, 1);
    raw_sample = 16'h0F0F;
    one_tick(1'b1);
    chk("R12 load beats read", rdy_n, 0);
    chk("R12 data loaded", data_out, 16'h8F0F);
  endtask

  task automatic t_read();
    pulse_rd();
    chk("R5 read releases ready", rdy_n, 1);
    chk("R4 status follows", status_rdy, 0);
    chk("R5 data kept", data_out, 16'h8F0F);
    pulse_rd();
    chk("R5 reread same data", data_out, 16'h8F0F);
  endtask

  task automatic t_unipolar();
    logic [15:0] ins [5]  = '{16'h1234, 16'h4000, 16'h8000, 16'h7FFF, 16'h0000};
    logic [15:0] outs [5] = '{16'h2468, 16'h8001, 16'h0000, 16'hFFFF, 16'h0000};
    int n, r;
    unipolar = 1'b1;
    for (int k = 0; k < 5; k++) begin
      raw_sample = ins[k];
      wait_ready(1000, n, r);
      chk("R2 period in unipolar", n, 312);
      chk("R8 straight binary", data_out, outs[k]);
    end
  endtask

  task automatic t_restart();
    int n, r;
    for (int i = 0; i < 100; i++) one_tick(1'b0);
    chk("R4 still ready before restart", rdy_n, 0);
    @(negedge clk); cfg_change = 1'b1;
    @(negedge clk); cfg_change = 1'b0;
    chk("R3 restart releases ready", rdy_n, 1);
    wait_ready(1000, n, r);
    chk("R3 two periods after restart", n, 624);
  endtask

  task automatic t_clamp();
    int n, r;
    write_sf(8'd5);
    wait_ready(1000, n, r);
    chk("R10 SF5 first result as SF13", n, 624);
    wait_ready(1000, n, r);
    chk("R10 SF5 period as SF13", n, 312);
  endtask

  task automatic t_sf_max();
    int n, r;
    write_sf(8'd255);
    wait_ready(13000, n, r);
    chk("R3 R2 first result SF255", n, 12240);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mod_tick = 1'b0; standby = 1'b0; cfg_change = 1'b0;
    sf_wr = 1'b0; sf_wdata = '0; unipolar = 1'b0; raw_sample = '0; rd_done = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_default_start();
    t_write_ignored();
    t_standby();
    t_collide();
    t_read();
    t_unipolar();
    t_restart();
    t_clamp();
    t_sf_max();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule